// File: doc/BRIEF.md
# Branch Condition Comparator

The block decides whether a conditional branch is taken. It takes two register operands, a 3-bit condition code and an enable, and produces a taken flag and a flag for a reserved condition code. Equal, not-equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal are all derived from a single shared adder. There are no per-condition comparators.

When the enable is high, the adder runs in subtract mode. In that mode it inverts the second operand and injects a carry of one. Equality is true when the difference is all zeros. Unsigned less-than is true when the subtraction produces no carry-out. Signed less-than reuses the same carry path after the top bit of both operands has been flipped. The selection logic works in two steps. Bit 2 of the code chooses between the equality result and the less-than result. Bit 0 then inverts the chosen result, which gives the complementary condition.

The datapath is combinational. A parameter can add one output register, with asynchronous active-low reset, in front of the outputs. The block has no state machine. Its only state is that optional output stage, which either holds its reset value or follows the combinational result one cycle late.

Top module: `brc_unit`

## Requirements
- R1: With the enable high and code 3'b000, taken is 1 exactly when the two operands are bit-for-bit equal.
- R2: With the enable high and code 3'b001, taken is 1 exactly when the operands differ.
- R3: With the enable high and code 3'b100, taken is 1 exactly when operand A is less than operand B as two's-complement numbers of XLEN bits, with the most significant bit as sign.
- R4: With the enable high and code 3'b101, taken is 1 exactly when operand A is greater than or equal to operand B as two's-complement numbers.
- R5: With the enable high, code 3'b110 takes the branch when A is less than B as unsigned numbers, and code 3'b111 takes it when A is greater than or equal to B as unsigned numbers.
- R6: With the enable high, codes 3'b010 and 3'b011 set the illegal flag to 1 and force taken to 0. The other six codes leave the illegal flag at 0.
- R7: With the enable low, taken and illegal are both 0 for any operands and code.
- R8: With REGISTERED=1, both outputs reflect the inputs presented one clock earlier, and they are 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| br_en | input | 1 | A branch is being evaluated; forces the adder into subtract mode |
| opnd_a | input | XLEN | First register operand |
| opnd_b | input | XLEN | Second register operand |
| cond_code | input | 3 | Branch condition code |
| taken_o | output | 1 | Branch condition is true |
| illegal_o | output | 1 | Condition code is reserved |

## Verification
The hardest cases to reach are those where only the sign bit decides the answer. These are operand pairs with different top bits, where the signed and unsigned orderings disagree, and pairs that are exactly equal, which uniform random operands almost never produce. The stimulus therefore crosses a set of edge values (zero, one, all-ones, the most negative and the most positive signed values) against each other under all eight codes. The random phase copies operand A into B in one case of four and forces opposing top bits in another, so that both boundaries are exercised many times.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        CC_EQ   = 3'b000,
        CC_NE   = 3'b001,
        CC_RSVA = 3'b010,
        CC_RSVB = 3'b011,
        CC_LT   = 3'b100,
        CC_GE   = 3'b101,
        CC_LTU  = 3'b110,
        CC_GEU  = 3'b111
    } cond_code_e;

    typedef struct packed {
        logic taken;
        logic illegal;
    } br_result_t;

    localparam br_result_t BR_IDLE = '{taken: 1'b0, illegal: 1'b0};

    // A code wants the signed ordering when it is a less-than family code
    // (bit 2 set) and not one of the unsigned pair (bit 1 clear).
    function automatic logic needs_signed(input logic [2:0] code);
        return code[2] & ~code[1];
    endfunction

endpackage

// File: rtl/brc_operand_prep.sv
module brc_operand_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] raw_a,
    input  logic [XLEN-1:0] raw_b,
    input  logic            flip_sign,
    output logic [XLEN-1:0] prep_a,
    output logic [XLEN-1:0] prep_b
);
    localparam int MSB = XLEN - 1;

    // Flipping the top bit of both operands maps the signed ordering onto
    // the unsigned one and leaves equality untouched.
    always_comb begin
        prep_a      = raw_a;
        prep_b      = raw_b;
        prep_a[MSB] = raw_a[MSB] ^ flip_sign;
        prep_b[MSB] = raw_b[MSB] ^ flip_sign;
    end
endmodule

// File: rtl/brc_addsub.sv
module brc_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] add_a,
    input  logic [XLEN-1:0] add_b,
    input  logic            sub,
    output logic [XLEN-1:0] sum,
    output logic            carry_out
);
    localparam int EXT = XLEN + 1;

    logic [XLEN-1:0] b_cond;
    logic [EXT-1:0]  wide;

    always_comb begin
        b_cond = add_b ^ {XLEN{sub}};
        wide   = {1'b0, add_a} + {1'b0, b_cond} + EXT'(sub);
    end

    assign sum       = wide[XLEN-1:0];
    assign carry_out = wide[XLEN];
endmodule

// File: rtl/brc_resolve.sv
module brc_resolve #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]       diff,
    input  logic                  carry_out,
    input  logic                  enable,
    input  logic [2:0]            code,
    output brc_pkg::br_result_t   result
);
    import brc_pkg::*;

    logic zero_prim;
    logic less_prim;
    logic chosen;
    logic reserved;

    always_comb begin
        zero_prim = ~|diff;
        less_prim = ~carry_out;
        chosen    = code[2] ? less_prim : zero_prim;
        reserved  = ~code[2] & code[1];
        if (!enable) begin
            result = BR_IDLE;
        end else if (reserved) begin
            result = '{taken: 1'b0, illegal: 1'b1};
        end else begin
            result = '{taken: chosen ^ code[0], illegal: 1'b0};
        end
    end
endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
    parameter int XLEN       = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_en,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [2:0]      cond_code,
    output logic            taken_o,
    output logic            illegal_o
);
    import brc_pkg::*;

    logic [XLEN-1:0] pa;
    logic [XLEN-1:0] pb;
    logic [XLEN-1:0] diff;
    logic            cout;
    br_result_t      comb_res;
    br_result_t      out_res;

    brc_operand_prep #(.XLEN(XLEN)) u_prep (
        .raw_a     (opnd_a),
        .raw_b     (opnd_b),
        .flip_sign (needs_signed(cond_code)),
        .prep_a    (pa),
        .prep_b    (pb)
    );

    brc_addsub #(.XLEN(XLEN)) u_addsub (
        .add_a     (pa),
        .add_b     (pb),
        .sub       (br_en),
        .sum       (diff),
        .carry_out (cout)
    );

    brc_resolve #(.XLEN(XLEN)) u_resolve (
        .diff      (diff),
        .carry_out (cout),
        .enable    (br_en),
        .code      (cond_code),
        .result    (comb_res)
    );

    generate
        if (REGISTERED) begin : g_reg
            br_result_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= BR_IDLE;
                else        res_q <= comb_res;
            end
            assign out_res = res_q;
        end else begin : g_comb
            assign out_res = comb_res;
        end
    endgenerate

    assign taken_o   = out_res.taken;
    assign illegal_o = out_res.illegal;
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter int XLEN       = 32,
    parameter bit REGISTERED = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            br_en,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [2:0]      cond_code,
    input logic            taken_o,
    input logic            illegal_o,
    input brc_pkg::br_result_t comb_res
);
    p_beq_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code == 3'b000 && opnd_a == opnd_b) |-> comb_res.taken);

    p_bne_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code == 3'b001 && opnd_a == opnd_b) |-> !comb_res.taken);

    p_blt_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code == 3'b100 && opnd_a == opnd_b) |-> !comb_res.taken);

    p_bge_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code == 3'b101 && opnd_a == opnd_b) |-> comb_res.taken);

    p_bgeu_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code == 3'b111 && opnd_a == opnd_b) |-> comb_res.taken);

    p_reserved_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_code[2:1] == 2'b01) |-> (comb_res.illegal && !comb_res.taken));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> (comb_res == brc_pkg::BR_IDLE));

    p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && illegal_o));

    p_stage_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (REGISTERED != 0) |=> (taken_o == $past(comb_res.taken)
                               && illegal_o == $past(comb_res.illegal)));
endmodule

bind brc_unit brc_unit_chk #(.XLEN(XLEN), .REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_en     (br_en),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cond_code (cond_code),
    .taken_o   (taken_o),
    .illegal_o (illegal_o),
    .comb_res  (comb_res)
);

// File: tb/brc_unit_test.sv
`timescale 1ns/1ps
module brc_unit_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            br_en = 1'b0;
    logic [XLEN-1:0] opnd_a = '0;
    logic [XLEN-1:0] opnd_b = '0;
    logic [2:0]      cond_code = 3'b000;
    logic            taken_o;
    logic            illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brc_unit #(.XLEN(XLEN), .REGISTERED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .br_en(br_en), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .cond_code(cond_code),
        .taken_o(taken_o), .illegal_o(illegal_o)
    );

    function automatic logic ref_taken(input logic en, input logic [2:0] c,
                                       input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        if (!en) return 1'b0;
        case (c)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) <  $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a <  b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ref_illegal(input logic en, input logic [2:0] c);
        return en && (c == 3'b010 || c == 3'b011);
    endfunction

    function automatic string tag_of(input logic en, input logic [2:0] c);
        if (!en) return "R7";
        case (c)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b100:  return "R3";
            3'b101:  return "R4";
            3'b110, 3'b111: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge; the registered result is visible after the
    // next rising edge, so sample at the falling edge that follows it.
    task automatic apply(input logic en, input logic [2:0] c,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        br_en = en; cond_code = c; opnd_a = a; opnd_b = b;
        @(negedge clk);
        check(tag_of(en, c), $sformatf("taken c=%b a=%h b=%h", c, a, b),
              taken_o, ref_taken(en, c, a, b));
        check(en ? "R6" : "R7", $sformatf("illegal c=%b", c),
              illegal_o, ref_illegal(en, c));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [XLEN-1:0] edges [5];
        int unsigned seed;
        edges[0] = '0;
        edges[1] = 32'h0000_0001;
        edges[2] = '1;
        edges[3] = 32'h8000_0000;
        edges[4] = 32'h7fff_ffff;
        seed = 32'd1357;
        void'($urandom(seed));

        // R8: outputs held at zero during reset even with a true condition
        br_en = 1'b1; cond_code = 3'b000; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        check("R8", "taken in reset", taken_o, 1'b0);
        check("R8", "illegal in reset", illegal_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "taken one cycle after reset", taken_o, 1'b1);

        // R8: a one-cycle pulse of a reserved code shows for exactly one cycle
        cond_code = 3'b010;
        @(negedge clk);
        cond_code = 3'b000; opnd_b = 32'h1;
        check("R8", "delayed illegal", illegal_o, 1'b1);
        @(negedge clk);
        check("R8", "illegal cleared next cycle", illegal_o, 1'b0);
        check("R8", "taken follows previous inputs", taken_o, 1'b0);

        // Edge-value cross under all codes, enabled and disabled
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int c = 0; c < 8; c++) begin
                    apply(1'b1, 3'(c), edges[i], edges[j]);
                    if (c == 0 || c == 5) apply(1'b0, 3'(c), edges[i], edges[j]);
                end

        // Biased random: equal operands and opposing sign bits
        for (int n = 0; n < 3000; n++) begin
            logic [XLEN-1:0] a;
            logic [XLEN-1:0] b;
            int unsigned mode;
            a = $urandom;
            b = $urandom;
            mode = $urandom_range(0, 3);
            if (mode == 0) b = a;
            else if (mode == 1) b[XLEN-1] = ~a[XLEN-1];
            apply(($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)), a, b);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule